// File: doc/BRIEF.md
# FIFO Occupancy Interrupt Flag Generator

This block raises one interrupt flag for a receive FIFO and one for a transmit FIFO of a serial-style peripheral. It tracks how full each FIFO is from the push and pop strobes it receives. The data path pushes into the receive side and pops from the transmit side. The CPU pops from the receive side when it reads the data register, and pushes into the transmit side when it writes it. A separate 2-bit select for each direction compares that occupancy against a threshold, which gives a level condition.

The flags are persistent. A flag goes high in the cycle after its condition is true. While the condition stays true, software cannot lower the flag. To acknowledge an interrupt, software must first move data through the data register until the condition goes away, and only then pulse the flag clear.

An optional drain variant applies to the receive side. When it is selected, the receive condition stays asserted after it first fires, until the FIFO has been read completely empty. While the module enable is low, both flags are held at zero and both occupancy counts are held at zero. Because the transmit FIFO is empty when the module is enabled, the transmit flag rises right after enable.

Top module: `fifo_level_irq`

## Requirements
- R1: Each occupancy count (0..8) rises by one on an accepted push and falls by one on an accepted pop. A push is refused at 8 and a pop is refused at 0. A push and a pop in the same cycle leave the count unchanged, except that at 8 only the pop is accepted and at 0 only the push is accepted. Both counts read 0 after reset.
- R2: The receive condition depends on rx_mode as follows: 2'b00 holds at count >= 1, 2'b01 at count >= 4, 2'b10 at count >= 6, and 2'b11 at count == 8.
- R3: The transmit condition depends on tx_mode as follows: 2'b00 holds at count <= 7, 2'b01 at count == 0, 2'b10 at count <= 4, and 2'b11 at count == 0 with tx_shift_idle high.
- R4: A flag reads 1 in the cycle after any cycle in which its condition is true while enabled. In the cycle in which the condition first becomes true, the flag keeps its old value.
- R5: A flag clear pulse in a cycle where the condition is true has no effect, so the flag is 1 in the next cycle.
- R6: A flag clear pulse in a cycle where the condition is false drops the flag in the next cycle. Without a clear pulse, a set flag stays set after its condition goes false.
- R7: While enable is low, both flags read 0 in the next cycle and both counts are held at 0. Pushes and pops are ignored while enable is low.
- R8: In the cycle after enable rises, tx_irq reads 1 when tx_shift_idle is high, for every tx_mode.
- R9: With rx_drain_all high, once the receive condition is true it stays true until the receive count reaches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low clears counts and flags |
| rx_mode | input | 2 | Receive threshold select |
| tx_mode | input | 2 | Transmit threshold select |
| rx_drain_all | input | 1 | Receive condition holds until the FIFO is empty |
| rx_push | input | 1 | Data path wrote a receive entry |
| rx_pop | input | 1 | CPU read the receive data register |
| tx_push | input | 1 | CPU wrote the transmit data register |
| tx_pop | input | 1 | Data path took a transmit entry |
| tx_shift_idle | input | 1 | Transmit shifter has no frame in progress |
| rx_flag_clr | input | 1 | Software clear pulse for the receive flag |
| tx_flag_clr | input | 1 | Software clear pulse for the transmit flag |
| rx_irq | output | 1 | Receive interrupt flag |
| tx_irq | output | 1 | Transmit interrupt flag |
| rx_count | output | 4 | Receive FIFO occupancy |
| tx_count | output | 4 | Transmit FIFO occupancy |

## Verification
The bench drives a clear pulse in the same cycle as a true condition. A design in which the clear wins would drop the flag, when it must stay 1. The bench also checks that a flag set by a condition that has since gone stays latched until a clear arrives. A design that simply follows the level would drop the flag on its own.

The bench steps the receive count across every threshold in every mode, and it pushes into a full FIFO and pops from an empty one. An off-by-one compare, or a count that wraps, would fire a flag at the wrong level or corrupt the count. The bench also toggles enable under random traffic. It then checks three things: that the transmit flag fires right after enable, that the drain variant holds the receive condition down to zero, and that strobes given while disabled leave no trace in the counts.

// File: rtl/fli_pkg.sv
package fli_pkg;
   typedef enum logic [1:0] {
      RX_ANY  = 2'b00,
      RX_HALF = 2'b01,
      RX_NEAR = 2'b10,
      RX_FULL = 2'b11
   } rx_sel_e;

   typedef enum logic [1:0] {
      TX_ROOM    = 2'b00,
      TX_EMPTY   = 2'b01,
      TX_HALF    = 2'b10,
      TX_DRAINED = 2'b11
   } tx_sel_e;

   function automatic int unsigned cnt_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/fli_level_ctr.sv
module fli_level_ctr #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic          pop,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

   logic [CW-1:0] cnt_q;
   logic          take_push;
   logic          take_pop;

   // push refused at full, pop refused at empty; both judged on current count
   assign take_push = push && (cnt_q != FULL_LVL);
   assign take_pop  = pop  && (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else begin
         case ({take_push, take_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign count = cnt_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_LVL); // R1
   AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/fli_rx_cond.sv
module fli_rx_cond
   import fli_pkg::*;
#(
   parameter int unsigned DEPTH     = 8,
   parameter int unsigned CW        = 4,
   parameter bit          HAS_DRAIN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          drain_all,
   input  logic [1:0]    mode,
   input  logic [CW-1:0] count,
   output logic          cond
);
   localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);
   localparam logic [CW-1:0] LVL_NEAR = CW'(DEPTH - 2);
   localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);

   logic base;
   logic hold;

   always_comb begin
      unique case (rx_sel_e'(mode))
         RX_ANY:  base = (count != '0);
         RX_HALF: base = (count >= LVL_HALF);
         RX_NEAR: base = (count >= LVL_NEAR);
         RX_FULL: base = (count == LVL_FULL);
         default: base = 1'b0;
      endcase
   end

   generate
      if (HAS_DRAIN) begin : g_drain
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold_q <= 1'b0;
            else        hold_q <= enable && drain_all && cond;
         end
         assign hold = hold_q && (count != '0);

         AST_DRAIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && drain_all && cond) |=> (!drain_all || count == '0 || cond)); // R9
      end else begin : g_plain
         assign hold = 1'b0;
      end
   endgenerate

   assign cond = base || (drain_all && hold);
endmodule

// File: rtl/fli_tx_cond.sv
module fli_tx_cond
   import fli_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CW    = 4
) (
   input  logic [1:0]    mode,
   input  logic [CW-1:0] count,
   input  logic          shift_idle,
   output logic          cond
);
   localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);
   localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);

   always_comb begin
      unique case (tx_sel_e'(mode))
         TX_ROOM:    cond = (count != LVL_FULL);
         TX_EMPTY:   cond = (count == '0);
         TX_HALF:    cond = (count <= LVL_HALF);
         TX_DRAINED: cond = (count == '0) && shift_idle;
         default:    cond = 1'b0;
      endcase
   end
endmodule

// File: rtl/fli_sticky_flag.sv
module fli_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic cond,
   input  logic clr,
   output logic flag
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (!enable) flag_q <= 1'b0;
      else if (cond)    flag_q <= 1'b1;
      else if (clr)     flag_q <= 1'b0;
   end

   assign flag = flag_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cond) |=> flag_q); // R5
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !cond && clr) |=> !flag_q); // R6
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && flag_q && !clr) |=> flag_q); // R6
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !flag_q); // R7
endmodule

// File: rtl/fifo_level_irq.sv
module fifo_level_irq
   import fli_pkg::*;
#(
   parameter int unsigned DEPTH     = 8,
   parameter bit          HAS_DRAIN = 1'b1,
   parameter int unsigned CW        = cnt_width(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [1:0]    rx_mode,
   input  logic [1:0]    tx_mode,
   input  logic          rx_drain_all,
   input  logic          rx_push,
   input  logic          rx_pop,
   input  logic          tx_push,
   input  logic          tx_pop,
   input  logic          tx_shift_idle,
   input  logic          rx_flag_clr,
   input  logic          tx_flag_clr,
   output logic          rx_irq,
   output logic          tx_irq,
   output logic [CW-1:0] rx_count,
   output logic [CW-1:0] tx_count
);
   initial begin
      assert (DEPTH >= 4 && DEPTH % 2 == 0)
         else $error("fifo_level_irq: DEPTH must be even and at least 4");
      assert (CW >= cnt_width(DEPTH))
         else $error("fifo_level_irq: CW too narrow for DEPTH");
   end

   logic rx_cond;
   logic tx_cond;

   fli_level_ctr #(.DEPTH(DEPTH), .CW(CW)) u_rx_ctr (
      .clk(clk), .rst_n(rst_n), .clear(!enable),
      .push(rx_push), .pop(rx_pop), .count(rx_count));

   fli_level_ctr #(.DEPTH(DEPTH), .CW(CW)) u_tx_ctr (
      .clk(clk), .rst_n(rst_n), .clear(!enable),
      .push(tx_push), .pop(tx_pop), .count(tx_count));

   fli_rx_cond #(.DEPTH(DEPTH), .CW(CW), .HAS_DRAIN(HAS_DRAIN)) u_rx_cond (
      .clk(clk), .rst_n(rst_n), .enable(enable), .drain_all(rx_drain_all),
      .mode(rx_mode), .count(rx_count), .cond(rx_cond));

   fli_tx_cond #(.DEPTH(DEPTH), .CW(CW)) u_tx_cond (
      .mode(tx_mode), .count(tx_count), .shift_idle(tx_shift_idle), .cond(tx_cond));

   fli_sticky_flag u_rx_flag (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cond(rx_cond),
      .clr(rx_flag_clr), .flag(rx_irq));

   fli_sticky_flag u_tx_flag (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cond(tx_cond),
      .clr(tx_flag_clr), .flag(tx_irq));

   AST_TX_AT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(enable) && tx_shift_idle) |=> tx_irq); // R8
   AST_FULL_RX_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && rx_count == CW'(DEPTH)) |=> rx_irq); // R2
endmodule

// File: tb/fifo_level_irq_tb_top.sv
module fifo_level_irq_tb_top;
   localparam int D = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 0, drain = 0, rxp = 0, rxo = 0, txp = 0, txo = 0, idle = 1, crx = 0, ctx = 0;
   logic [1:0] rxm = 2'b00, txm = 2'b00;
   logic rx_irq, tx_irq;
   logic [3:0] rx_count, tx_count;

   int checks = 0, failures = 0;
   int m_rx = 0, m_tx = 0;
   bit m_rf = 0, m_tf = 0, m_hold = 0;

   always #2.5 clk = ~clk;

   fifo_level_irq dut_i (
      .clk(clk), .rst_n(rst_n), .enable(en), .rx_mode(rxm), .tx_mode(txm),
      .rx_drain_all(drain), .rx_push(rxp), .rx_pop(rxo), .tx_push(txp), .tx_pop(txo),
      .tx_shift_idle(idle), .rx_flag_clr(crx), .tx_flag_clr(ctx),
      .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_count(rx_count), .tx_count(tx_count));

   function automatic bit rx_c(int c, logic [1:0] m);
      case (m)
         2'b00: return c >= 1;
         2'b01: return c >= D / 2;
         2'b10: return c >= D - 2;
         default: return c == D;
      endcase
   endfunction

   function automatic bit tx_c(int c, logic [1:0] m, logic idl);
      case (m)
         2'b00: return c <= D - 1;
         2'b01: return c == 0;
         2'b10: return c <= D / 2;
         default: return c == 0 && idl;
      endcase
   endfunction

   function automatic int next_cnt(int c, logic p, logic o);
      bit ap = p && c != D;
      bit ao = o && c != 0;
      return c + int'(ap) - int'(ao);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one clock: model advances from the inputs now applied, outputs compared after the edge
   task automatic step(input string tag);
      bit rc, n_rf, n_tf, n_hold;
      int n_rx, n_tx;
      rc = rx_c(m_rx, rxm) || (drain && m_hold && m_rx != 0);
      if (!en) begin
         n_rx = 0; n_tx = 0; n_rf = 0; n_tf = 0; n_hold = 0;
      end else begin
         n_rx = next_cnt(m_rx, rxp, rxo);
         n_tx = next_cnt(m_tx, txp, txo);
         n_rf = rc ? 1'b1 : (crx ? 1'b0 : m_rf);
         n_tf = tx_c(m_tx, txm, idle) ? 1'b1 : (ctx ? 1'b0 : m_tf);
         n_hold = drain && rc;
      end
      @(posedge clk);
      #1;
      m_rx = n_rx; m_tx = n_tx; m_rf = n_rf; m_tf = n_tf; m_hold = n_hold;
      chk(rx_count == m_rx, {tag, " rx_count"}, rx_count, m_rx);
      chk(tx_count == m_tx, {tag, " tx_count"}, tx_count, m_tx);
      chk(rx_irq == m_rf, {tag, " rx_irq"}, rx_irq, m_rf);
      chk(tx_irq == m_tf, {tag, " tx_irq"}, tx_irq, m_tf);
      @(negedge clk);
      rxp = 0; rxo = 0; txp = 0; txo = 0; crx = 0; ctx = 0;
   endtask

   task automatic rx_push_n(input int n, input string tag);
      for (int i = 0; i < n; i++) begin rxp = 1; step(tag); end
   endtask

   initial begin : watchdog
      #(5 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(rx_count == 0 && tx_count == 0, "R1 reset counts", rx_count + tx_count, 0);
      chk(!rx_irq && !tx_irq, "R7 reset flags", rx_irq + tx_irq, 0);
      rst_n = 1;
      @(negedge clk);
      // disabled: strobes ignored
      rxp = 1; txp = 1; step("R7 disabled push");
      chk(rx_count == 0 && tx_count == 0, "R7 ignored push", rx_count, 0);
      // enable: tx empty -> flag next cycle
      en = 1; txm = 2'b11; idle = 1; step("R8 enable");
      chk(tx_irq == 1, "R8 tx after enable", tx_irq, 1);
      // rx mode 01, threshold 4
      rxm = 2'b01;
      rx_push_n(4, "R2 fill half");
      chk(rx_count == 4 && rx_irq == 0, "R4 latency", rx_irq, 0);
      step("R4 set");
      chk(rx_irq == 1, "R4 flag set", rx_irq, 1);
      crx = 1; step("R5 clear blocked");
      chk(rx_irq == 1, "R5 clear ignored", rx_irq, 1);
      rxo = 1; crx = 1; step("R5 clear with pop");
      chk(rx_irq == 1, "R5 same cycle set wins", rx_irq, 1);
      step("R6 idle"); step("R6 idle");
      chk(rx_irq == 1, "R6 stays latched", rx_irq, 1);
      crx = 1; step("R6 clear");
      chk(rx_irq == 0, "R6 clear takes", rx_irq, 0);
      // every rx mode at every level
      for (int m = 0; m < 4; m++) begin
         rxm = 2'(m);
         while (m_rx > 0) begin rxo = 1; crx = 1; step("R2 drain"); end
         crx = 1; step("R2 clr");
         for (int k = 0; k <= D; k++) begin
            crx = 1; step("R2 level");
            chk(rx_irq == rx_c(k, 2'(m)), "R2 mode level", rx_irq, rx_c(k, 2'(m)));
            rxp = 1; step("R1 push");
         end
      end
      rxp = 1; rxo = 1; step("R1 full push+pop");
      chk(rx_count == D - 1, "R1 full both", rx_count, D - 1);
      // tx modes
      for (int m = 0; m < 4; m++) begin
         txm = 2'(m);
         for (int k = 0; k <= D; k++) begin
            idle = k[0];
            ctx = 1; step("R3 level");
            ctx = 1; step("R3 sample");
            chk(tx_irq == tx_c(k, 2'(m), idle), "R3 mode level", tx_irq, tx_c(k, 2'(m), idle));
            txp = 1; step("R1 tx push");
         end
         while (m_tx > 0) begin txo = 1; step("R1 tx pop"); end
      end
      txp = 1; txo = 1; step("R1 empty push+pop");
      chk(tx_count == 1, "R1 empty both", tx_count, 1);
      // drain variant with full mode
      drain = 1; rxm = 2'b11;
      while (m_rx < D) begin rxp = 1; step("R9 fill"); end
      step("R9 fire");
      while (m_rx > 0) begin
         rxo = 1; crx = 1; step("R9 hold");
         if (m_rx > 0) chk(rx_irq == 1, "R9 held until empty", rx_irq, 1);
      end
      crx = 1; step("R9 empty");
      crx = 1; step("R9 cleared");
      chk(rx_irq == 0, "R9 clears at empty", rx_irq, 0);
      // disable clears everything
      rxp = 1; txp = 1; step("R7 pre");
      en = 0; step("R7 disable");
      chk(!rx_irq && !tx_irq && rx_count == 0 && tx_count == 0, "R7 off", rx_irq + tx_irq, 0);
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 99) < 2) en = ~en;
         if ($urandom_range(0, 99) < 5) begin
            rxm = 2'($urandom); txm = 2'($urandom); drain = 1'($urandom);
         end
         rxp = 1'($urandom); rxo = 1'($urandom); txp = 1'($urandom); txo = 1'($urandom);
         idle = 1'($urandom); crx = ($urandom_range(0, 3) == 0); ctx = ($urandom_range(0, 3) == 0);
         step("R1/R4/R5/R6/R9 random");
      end
      en = 0; step("R7 final");
      en = 1; idle = 1; step("R8 re-enable");
      chk(tx_irq == 1, "R8 tx after re-enable", tx_irq, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule